// File: doc/BRIEF.md
# Barrel Shifter with Carry

This block shifts or rotates a 32-bit data word and produces the shifted word, a carry-out bit and an invalid-request flag. It supports logical left, logical right, arithmetic right, rotate right and rotate-right-extended through the carry. The carry-out rules follow the usual conventions for condition-flag generation. The block only produces the carry-out value; writing it back is left to the surrounding datapath.

The operation and amount come from one of two sources. In immediate mode, a small decoder reads a 2-bit shift type and a 5-bit immediate from the instruction word. A layout input selects which of two field placements the decoder uses. In register mode, the caller supplies a 3-bit operation code and an 8-bit amount directly. A parameter can add an output register with a valid bit, which gives exactly one cycle of latency.

Top module: `barrel_shift_unit`

## Requirements
- R1: In register mode (`src_sel_i`=1), `reg_op_i` selects the operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate-right-extended. The amount is `reg_amt_i` (0 to 255).
- R2: In immediate mode (`src_sel_i`=0), the field placement depends on `layout_i`. With `layout_i`=0, the type is `opcode_i[6:5]` and imm5 is `opcode_i[11:7]`. With `layout_i`=1, the type is `opcode_i[5:4]` and imm5 is `{opcode_i[14:12], opcode_i[7:6]}`. Type 0 is left, 1 logical right, 2 arithmetic right and 3 rotate.
- R3: In immediate mode, imm5=0 with type 1 or 2 means an amount of 32. Type 3 with imm5=0 selects rotate-right-extended by 1. Type 3 with any other imm5 is a rotate by imm5.
- R4: For operations 0 to 3 with an amount of 0, the result equals the data and carry-out equals `carry_i`.
- R5: A logical left shift by 1 to 32 zero-fills and gives carry-out = data bit (32 − amount). Above 32, the result and the carry are both 0.
- R6: A logical right shift by 1 to 32 zero-fills and gives carry-out = data bit (amount − 1). Above 32, the result and the carry are both 0.
- R7: An arithmetic right shift fills from bit 31 and gives carry-out = data bit (amount − 1). For amounts of 32 or more, every result bit and the carry equal data bit 31.
- R8: A rotate right with a nonzero amount rotates by the amount modulo 32, and carry-out equals bit 31 of the result.
- R9: Rotate-right-extended with an amount of 1 gives the result `{carry_i, data[31:1]}` and carry-out = data bit 0.
- R10: The request is invalid in two cases: rotate-right-extended with an amount other than 1, or operation codes 5 to 7. An invalid request sets `invalid_o` and forces the result and the carry to 0.
- R11: With REG_OUT=1, all outputs appear one clock after the inputs are applied, and `valid_o` repeats `valid_i` from one cycle earlier. During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| src_sel_i | input | 1 | 0: decode from opcode, 1: register operation and amount |
| layout_i | input | 1 | Immediate field placement selector |
| opcode_i | input | 32 | Instruction word for immediate decoding |
| reg_op_i | input | 3 | Operation code in register mode |
| reg_amt_i | input | 8 | Shift amount in register mode |
| data_i | input | 32 | Data word |
| carry_i | input | 1 | Carry input |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry output |
| invalid_o | output | 1 | Invalid request |
| valid_o | output | 1 | Output valid |

## Verification
A wrong stage in the logarithmic rotator, or a wrong bound in the over-range detection, corrupts `result_o` or `carry_o` for the amounts concerned. The error appears one clock after the request. The bench therefore drives amounts of 31, 32, 33 and 255 as well as random ones. A decoder fault shows up only in immediate mode, as a wrong operation or amount. A fault in the output register would skew `valid_o` against `valid_i` on the very next cycle.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned OP_W   = 3;

  localparam logic [OP_W-1:0] SH_LSL = 3'd0;
  localparam logic [OP_W-1:0] SH_LSR = 3'd1;
  localparam logic [OP_W-1:0] SH_ASR = 3'd2;
  localparam logic [OP_W-1:0] SH_ROR = 3'd3;
  localparam logic [OP_W-1:0] SH_RRX = 3'd4;
endpackage

// File: rtl/shift_imm_decode.sv
module shift_imm_decode
  import shift_pkg::*;
#(
  parameter int unsigned AMT_W = 8
) (
  input  logic              layout_i,
  input  logic [INSN_W-1:0] opcode_i,
  output logic [OP_W-1:0]   op_o,
  output logic [AMT_W-1:0]  amt_o
);
  logic [1:0] typ;
  logic [4:0] imm5;

  always_comb begin
    if (layout_i) begin
      typ  = opcode_i[5:4];
      imm5 = {opcode_i[14:12], opcode_i[7:6]};
    end else begin
      typ  = opcode_i[6:5];
      imm5 = opcode_i[11:7];
    end
  end

  always_comb begin
    op_o  = SH_LSL;
    amt_o = AMT_W'(imm5);
    unique case (typ)
      2'd0: op_o = SH_LSL;
      2'd1: begin
        op_o = SH_LSR;
        if (imm5 == '0) amt_o = AMT_W'(32);
      end
      2'd2: begin
        op_o = SH_ASR;
        if (imm5 == '0) amt_o = AMT_W'(32);
      end
      default: begin
        if (imm5 == '0) begin
          op_o  = SH_RRX;
          amt_o = AMT_W'(1);
        end else begin
          op_o = SH_ROR;
        end
      end
    endcase
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              invalid_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  logic            over;
  logic            amt_zero;
  logic [SH_W:0]   amt_c;
  logic [DATA_W:0] lsl_w;
  logic [DATA_W:0] lsr_w;
  logic [DATA_W:0] asr_w;

  assign over     = amt_i > AMT_W'(DATA_W);
  assign amt_zero = amt_i == '0;
  assign amt_c    = over ? (SH_W+1)'(DATA_W) : amt_i[SH_W:0];

  // widened by one bit so the last bit shifted out lands in the carry slot
  assign lsl_w = {1'b0, data_i} << amt_c;
  assign lsr_w = {data_i, 1'b0} >> amt_c;
  assign asr_w = $unsigned($signed({data_i, 1'b0}) >>> amt_c);

  logic [DATA_W-1:0] rot_s [SH_W+1];
  assign rot_s[0] = data_i;
  for (genvar k = 0; k < SH_W; k++) begin : g_rot
    assign rot_s[k+1] = amt_i[k] ? {rot_s[k][(2**k)-1:0], rot_s[k][DATA_W-1:2**k]}
                                 : rot_s[k];
  end

  always_comb begin
    result_o  = data_i;
    carry_o   = carry_i;
    invalid_o = 1'b0;
    case (op_i)
      SH_LSL: if (!amt_zero) begin
        result_o = over ? '0   : lsl_w[DATA_W-1:0];
        carry_o  = over ? 1'b0 : lsl_w[DATA_W];
      end
      SH_LSR: if (!amt_zero) begin
        result_o = over ? '0   : lsr_w[DATA_W:1];
        carry_o  = over ? 1'b0 : lsr_w[0];
      end
      SH_ASR: if (!amt_zero) begin
        result_o = asr_w[DATA_W:1];
        carry_o  = asr_w[0];
      end
      SH_ROR: if (!amt_zero) begin
        result_o = rot_s[SH_W];
        carry_o  = rot_s[SH_W][DATA_W-1];
      end
      SH_RRX: begin
        if (amt_i == AMT_W'(1)) begin
          result_o = {carry_i, data_i[DATA_W-1:1]};
          carry_o  = data_i[0];
        end else begin
          result_o  = '0;
          carry_o   = 1'b0;
          invalid_o = 1'b1;
        end
      end
      default: begin
        result_o  = '0;
        carry_o   = 1'b0;
        invalid_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import shift_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned AMT_W   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              src_sel_i,
  input  logic              layout_i,
  input  logic [INSN_W-1:0] opcode_i,
  input  logic [OP_W-1:0]   reg_op_i,
  input  logic [AMT_W-1:0]  reg_amt_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              invalid_o,
  output logic              valid_o
);
  logic [OP_W-1:0]   dec_op;
  logic [AMT_W-1:0]  dec_amt;
  logic [OP_W-1:0]   core_op;
  logic [AMT_W-1:0]  core_amt;
  logic [DATA_W-1:0] core_res;
  logic              core_c;
  logic              core_inv;

  shift_imm_decode #(.AMT_W(AMT_W)) u_dec (
    .layout_i (layout_i),
    .opcode_i (opcode_i),
    .op_o     (dec_op),
    .amt_o    (dec_amt)
  );

  assign core_op  = src_sel_i ? reg_op_i  : dec_op;
  assign core_amt = src_sel_i ? reg_amt_i : dec_amt;

  shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .op_i      (core_op),
    .amt_i     (core_amt),
    .data_i    (data_i),
    .carry_i   (carry_i),
    .result_o  (core_res),
    .carry_o   (core_c),
    .invalid_o (core_inv)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        result_o  <= '0;
        carry_o   <= 1'b0;
        invalid_o <= 1'b0;
        valid_o   <= 1'b0;
      end else begin
        result_o  <= core_res;
        carry_o   <= core_c;
        invalid_o <= core_inv;
        valid_o   <= valid_i;
      end
    end
  end else begin : g_comb
    assign result_o  = core_res;
    assign carry_o   = core_c;
    assign invalid_o = core_inv;
    assign valid_o   = valid_i;
  end
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk
  import shift_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned AMT_W   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              src_sel_i,
  input logic              layout_i,
  input logic [INSN_W-1:0] opcode_i,
  input logic [DATA_W-1:0] data_i,
  input logic              carry_i,
  input logic [OP_W-1:0]   core_op,
  input logic [AMT_W-1:0]  core_amt,
  input logic [DATA_W-1:0] core_res,
  input logic              core_c,
  input logic              core_inv,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              invalid_o,
  input logic              valid_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  a_r4_zero_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_op <= SH_ROR && core_amt == '0) |-> (core_res == data_i && core_c == carry_i));

  a_r9_rrx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_op == SH_RRX && core_amt == AMT_W'(1)) |->
      (core_res[DATA_W-1] == carry_i && core_c == data_i[0] && !core_inv));

  a_r8_ror_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_op == SH_ROR && core_amt != '0) |-> core_c == core_res[DATA_W-1]);

  a_r10_inv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_inv |-> (core_res == '0 && !core_c));

  a_r3_rrx_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_sel_i && !layout_i && opcode_i[6:5] == 2'd3 && opcode_i[11:7] == 5'd0) |->
      (core_op == SH_RRX && core_amt == AMT_W'(1)));

  if (REG_OUT) begin : g_lat
    a_r11_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |-> (valid_o == $past(valid_i) && result_o == $past(core_res)
                 && carry_o == $past(core_c) && invalid_o == $past(core_inv)));
  end
endmodule

bind barrel_shift_unit shift_unit_chk #(
  .DATA_W(DATA_W), .AMT_W(AMT_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .src_sel_i (src_sel_i),
  .layout_i  (layout_i),
  .opcode_i  (opcode_i),
  .data_i    (data_i),
  .carry_i   (carry_i),
  .core_op   (core_op),
  .core_amt  (core_amt),
  .core_res  (core_res),
  .core_c    (core_c),
  .core_inv  (core_inv),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .invalid_o (invalid_o),
  .valid_o   (valid_o)
);

// File: tb/sim_barrel_shift_unit.sv
`timescale 1ns/1ps
module sim_barrel_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        src_sel = 1'b1;
  logic        layout = 1'b0;
  logic [31:0] opcode = '0;
  logic [2:0]  rop = '0;
  logic [7:0]  ramt = '0;
  logic [31:0] data = '0;
  logic        cin = 1'b0;
  logic [31:0] res;
  logic        cout, inv, vout;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  barrel_shift_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .src_sel_i(src_sel),
    .layout_i(layout), .opcode_i(opcode), .reg_op_i(rop), .reg_amt_i(ramt),
    .data_i(data), .carry_i(cin), .result_o(res), .carry_o(cout),
    .invalid_o(inv), .valid_o(vout)
  );

  // {invalid, carry, result}, built by single-bit steps
  function automatic logic [33:0] ref_shift(logic [2:0] op, logic [7:0] amt,
                                            logic [31:0] d, logic ci);
    logic [31:0] r;
    logic        c;
    r = d;
    c = ci;
    if (op > 3'd4) return {2'b10, 32'h0};
    if (op == 3'd4) begin
      if (amt != 8'd1) return {2'b10, 32'h0};
      return {1'b0, d[0], ci, d[31:1]};
    end
    for (int i = 0; i < int'(amt); i++) begin
      case (op)
        3'd0: begin c = r[31]; r = r << 1; end
        3'd1: begin c = r[0];  r = r >> 1; end
        3'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: r = {r[0], r[31:1]};
      endcase
    end
    if (op == 3'd3 && amt != 0) c = r[31];
    return {1'b0, c, r};
  endfunction

  function automatic string op_tag(logic [2:0] op, logic [7:0] amt);
    if (op > 3'd4) return "R10";
    if (op == 3'd4) return (amt == 8'd1) ? "R9" : "R10";
    if (amt == 0) return "R4";
    case (op)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [33:0] exp, logic expv);
    checks++;
    if ({inv, cout, res} !== exp || vout !== expv) begin
      errors++;
      $display("FAIL %s: got inv=%b c=%b res=%h v=%b, exp inv=%b c=%b res=%h v=%b",
               tag, inv, cout, res, vout, exp[33], exp[32], exp[31:0], expv);
    end
  endtask

  // register mode, R1; result visible one clock later (R11)
  task automatic run_reg(logic [2:0] op, logic [7:0] amt, logic [31:0] d, logic ci);
    @(negedge clk);
    src_sel = 1'b1; rop = op; ramt = amt; data = d; cin = ci; valid_i = 1'b1;
    @(negedge clk);
    check({"R1/", op_tag(op, amt)}, ref_shift(op, amt, d, ci), 1'b1);
  endtask

  // immediate mode, R2/R3
  task automatic run_imm(logic lay, logic [1:0] typ, logic [4:0] imm5,
                         logic [31:0] filler, logic [31:0] d, logic ci);
    logic [31:0] opc;
    logic [2:0]  eop;
    logic [7:0]  eamt;
    opc = filler;
    if (lay) begin
      opc[5:4] = typ; opc[14:12] = imm5[4:2]; opc[7:6] = imm5[1:0];
    end else begin
      opc[6:5] = typ; opc[11:7] = imm5;
    end
    eamt = {3'b0, imm5};
    case (typ)
      2'd0: eop = 3'd0;
      2'd1: begin eop = 3'd1; if (imm5 == 0) eamt = 8'd32; end
      2'd2: begin eop = 3'd2; if (imm5 == 0) eamt = 8'd32; end
      default: begin
        if (imm5 == 0) begin eop = 3'd4; eamt = 8'd1; end
        else eop = 3'd3;
      end
    endcase
    @(negedge clk);
    src_sel = 1'b0; layout = lay; opcode = opc; data = d; cin = ci; valid_i = 1'b1;
    rop = $urandom_range(7, 5); ramt = $urandom;  // register fields must be ignored
    @(negedge clk);
    check({"R2/R3/", op_tag(eop, eamt)}, ref_shift(eop, eamt, d, ci), 1'b1);
  endtask

  function automatic logic [7:0] pick_amt();
    case ($urandom_range(6, 0))
      0: return 8'd0;
      1: return 8'd1;
      2: return 8'd31;
      3: return 8'd32;
      4: return 8'd33;
      5: return 8'd255;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R11: watchdog expired, got no completion, exp finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R11 reset", 34'h0, 1'b0);
    rst_n = 1'b1;

    // directed edges
    run_reg(3'd0, 8'd32,  32'h8000_0001, 1'b0);  // R5 carry = bit0
    run_reg(3'd0, 8'd33,  32'hFFFF_FFFF, 1'b1);  // R5 over range
    run_reg(3'd0, 8'd1,   32'h8000_0000, 1'b0);  // R5
    run_reg(3'd1, 8'd32,  32'h8000_0000, 1'b0);  // R6
    run_reg(3'd1, 8'd40,  32'hFFFF_FFFF, 1'b1);  // R6 over range
    run_reg(3'd2, 8'd32,  32'h8000_0000, 1'b0);  // R7
    run_reg(3'd2, 8'd200, 32'h9000_0000, 1'b0);  // R7 big
    run_reg(3'd2, 8'd4,   32'h7000_0008, 1'b0);  // R7 positive
    run_reg(3'd3, 8'd32,  32'h8000_0001, 1'b0);  // R8 modulo -> unchanged
    run_reg(3'd3, 8'd36,  32'h0000_00F1, 1'b0);  // R8
    run_reg(3'd1, 8'd0,   32'h1234_5678, 1'b1);  // R4
    run_reg(3'd4, 8'd1,   32'h0000_0003, 1'b1);  // R9
    run_reg(3'd4, 8'd2,   32'hFFFF_FFFF, 1'b1);  // R10
    run_reg(3'd4, 8'd0,   32'hFFFF_FFFF, 1'b1);  // R10
    run_reg(3'd6, 8'd0,   32'hFFFF_FFFF, 1'b1);  // R10
    run_imm(1'b0, 2'd1, 5'd0, 32'hA5A5_A5A5, 32'h8000_0000, 1'b0);  // R3 -> 32
    run_imm(1'b1, 2'd2, 5'd0, 32'h0F0F_0F0F, 32'h8000_0000, 1'b0);  // R3
    run_imm(1'b0, 2'd3, 5'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);  // R3 rrx
    run_imm(1'b1, 2'd3, 5'd0, 32'h0000_0000, 32'h0000_0002, 1'b1);  // R3 rrx
    run_imm(1'b1, 2'd0, 5'd17, 32'h1357_9BDF, 32'hDEAD_BEEF, 1'b0); // R2

    // R11: idle request carries valid low
    @(negedge clk);
    valid_i = 1'b0; src_sel = 1'b1; rop = 3'd0; ramt = 8'd3; data = 32'h1; cin = 1'b0;
    @(negedge clk);
    check("R11 valid low", ref_shift(3'd0, 8'd3, 32'h1, 1'b0), 1'b0);

    for (int n = 0; n < 2500; n++) begin
      if ($urandom_range(1, 0) == 0)
        run_reg(3'($urandom_range(7, 0)), pick_amt(), $urandom, 1'($urandom));
      else
        run_imm(1'($urandom), 2'($urandom), 5'($urandom), $urandom, $urandom,
                1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule